// File: doc/BRIEF.md
# Section Alarm Serial Bus Receiver

This block takes remote-defect feedback (an RDI flag and eight REI bits) and the two APS bytes K1 and K2 from a one-bit serial line. It turns them into parallel outputs that the transmit overhead inserter can use. Each frame carries 72 bits, split into nine time slots of eight bits. One frame repeats every 125 µs, so the bit clock runs at 576 kHz.

A single mode input picks where the bit timing comes from. With `timing_own` high, the block divides the system clock by `DIV` to make its own bit clock and frame pulse. It drives both on output pins, and the far end shifts data out against them. With `timing_own` low, the bit clock and frame pulse arrive from outside, for example from another device's receiver. The block brings both into the system clock domain through two-flop synchronizers and samples data on the rising edge of the synchronized clock. That external timing may drift against the local frame rate, so a frame whose length is wrong is dropped and counted. This does not disturb the frames on either side of it.

All four fields change together, once per good frame. The change comes with a one-cycle strobe, issued when the frame pulse that closes the frame arrives.

Top module: `sa_serial_rx`

## Requirements
- R1: From reset until the first accepted frame, `rdi_flag`, `rei_byte`, `aps_k1`, `aps_k2`, `word_valid` and `bad_frame_cnt` are all zero.
- R2: With `timing_own` high, `bit_clk_out` has a period of `DIV` system clocks. It is high for the first `DIV/2` of them. `frame_out` is high for exactly one bit period (`DIV` clocks) out of every 72 (72·`DIV` clocks), and it rises together with `bit_clk_out`.
- R3: With `timing_own` low, `bit_clk_out` and `frame_out` stay low.
- R4: Bit position 0 of a frame (the bit that carries the frame pulse) is RDI. Positions 8..15 are REI, positions 16..23 are K1 and positions 24..31 are K2, each sent MSB first. Positions 1..7 and 32..71 have no effect on any output.
- R5: With `timing_own` high, `ser_data` is sampled in the last system clock of each bit period of the generated timing.
- R6: With `timing_own` low, `ser_data` is sampled at each rising edge of `bit_clk_in` after synchronization. A bit whose `frame_in` is high at that edge is position 0 of a new frame.
- R7: A frame is accepted only when exactly 72 bits lie between its frame pulse and the next one. A shorter or longer frame updates no output, and `bad_frame_cnt` rises by one.
- R8: An accepted frame updates all four fields in the same clock, with `word_valid` high for that single clock. The outputs hold their values at all other times.
- R9: The good frame that follows a discarded one is accepted with its own contents.
- R10: A change of `timing_own` restarts framing. The first frame pulse afterwards opens a frame without counting an error, and the frame it opens is accepted if it is complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| timing_own | input | 1 | 1: block generates bit timing; 0: timing comes from outside |
| bit_clk_in | input | 1 | External bit clock (used when `timing_own` is 0) |
| frame_in | input | 1 | External frame pulse, high during bit 0 |
| ser_data | input | 1 | Serial data |
| bit_clk_out | output | 1 | Generated bit clock |
| frame_out | output | 1 | Generated frame pulse |
| rdi_flag | output | 1 | Received RDI |
| rei_byte | output | 8 | Received REI bits |
| aps_k1 | output | 8 | Received K1 byte |
| aps_k2 | output | 8 | Received K2 byte |
| word_valid | output | 1 | One-clock strobe when the fields above update |
| bad_frame_cnt | output | ERR_W | Saturating count of discarded frames |

## Verification
Suppose the bit counter, the started flag or a staging bit goes wrong. The damage reaches the ports no later than the next frame pulse, one frame period (72 bit periods) later. It shows up as a missing or extra `word_valid`, a field built from the wrong bit position, or a `bad_frame_cnt` step on a good frame. The bench models frame boundaries and contents on its own. At every clock it compares the outputs against the model's held values, and at each strobe against the next expected frame. So a shifted bit, a stale field or a spurious update is caught in the clock where it appears. It also checks that an error is counted only when a frame is short or long, and never after a mode change.

// File: rtl/sa_rx_pkg.sv
package sa_rx_pkg;
  localparam int SLOT_W     = 8;
  localparam int NUM_SLOTS  = 9;
  localparam int FRAME_BITS = SLOT_W * NUM_SLOTS;
  localparam int RDI_POS    = 0;
  localparam int REI_POS    = SLOT_W;
  localparam int K1_POS     = 2 * SLOT_W;
  localparam int K2_POS     = 3 * SLOT_W;
  localparam int USED_BITS  = 4 * SLOT_W;

  typedef struct packed {
    logic              rdi;
    logic [SLOT_W-1:0] rei;
    logic [SLOT_W-1:0] k1;
    logic [SLOT_W-1:0] k2;
  } sa_fields_t;
endpackage

// File: rtl/sa_rx_timing_gen.sv
module sa_rx_timing_gen
  import sa_rx_pkg::*;
#(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick,
  output logic frm_at_tick,
  output logic out_clk,
  output logic out_frm
);
  localparam int DIV_W = $clog2(DIV);
  localparam int BIT_W = $clog2(FRAME_BITS);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);
  localparam logic [DIV_W-1:0] DIV_HALF = DIV_W'(DIV / 2);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_BITS - 1);

  logic [DIV_W-1:0] div_q, div_d;
  logic [BIT_W-1:0] bit_q, bit_d;

  always_comb begin
    div_d = div_q;
    bit_d = bit_q;
    if (!en) begin
      div_d = '0;
      bit_d = '0;
    end else if (div_q == DIV_LAST) begin
      div_d = '0;
      bit_d = (bit_q == BIT_LAST) ? '0 : bit_q + 1'b1;
    end else begin
      div_d = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      bit_q <= '0;
    end else begin
      div_q <= div_d;
      bit_q <= bit_d;
    end
  end

  assign tick        = en && (div_q == DIV_LAST);
  assign frm_at_tick = (bit_q == '0);
  assign out_clk     = en && (div_q < DIV_HALF);
  assign out_frm     = en && (bit_q == '0);

  // R2: the frame pulse opens together with a bit clock high phase
  a_r2_frm_with_clk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_frm) |-> $rose(out_clk));
  // R5: sampling point is followed by the start of the next bit period
  a_r5_tick_then_rise: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (out_clk || !en));
endmodule

// File: rtl/sa_rx_ext_sync.sv
module sa_rx_ext_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk,
  input  logic ext_frm,
  input  logic ext_dat,
  output logic tick,
  output logic frm_at_tick,
  output logic bit_at_tick
);
  logic clk_s1, clk_s2, clk_d;
  logic frm_s1, frm_s2;
  logic dat_s1, dat_s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_s1 <= 1'b0;
      clk_s2 <= 1'b0;
      clk_d  <= 1'b0;
      frm_s1 <= 1'b0;
      frm_s2 <= 1'b0;
      dat_s1 <= 1'b0;
      dat_s2 <= 1'b0;
    end else begin
      clk_s1 <= ext_clk;
      clk_s2 <= clk_s1;
      clk_d  <= clk_s2;
      frm_s1 <= ext_frm;
      frm_s2 <= frm_s1;
      dat_s1 <= ext_dat;
      dat_s2 <= dat_s1;
    end
  end

  assign tick        = clk_s2 && !clk_d;
  assign frm_at_tick = frm_s2;
  assign bit_at_tick = dat_s2;

  // R6: one sample per external rising edge
  a_r6_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/sa_rx_deframer.sv
module sa_rx_deframer
  import sa_rx_pkg::*;
#(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode,
  input  logic             tick,
  input  logic             frm,
  input  logic             bit_in,
  output sa_fields_t       fields,
  output logic             valid,
  output logic [ERR_W-1:0] err_cnt
);
  localparam int CNT_W = $clog2(FRAME_BITS + 2);
  localparam int IDX_W = $clog2(USED_BITS);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_OVF  = CNT_W'(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_USED = CNT_W'(USED_BITS);

  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic                 started_q, started_d;
  logic                 mode_q;
  logic [USED_BITS-1:0] stage_q, stage_d;
  sa_fields_t           fields_q, fields_d;
  logic                 valid_q, valid_d;
  logic [ERR_W-1:0]     err_q, err_d;

  always_comb begin
    cnt_d     = cnt_q;
    started_d = started_q;
    stage_d   = stage_q;
    fields_d  = fields_q;
    valid_d   = 1'b0;
    err_d     = err_q;
    if (mode != mode_q) begin
      started_d = 1'b0;
      cnt_d     = '0;
    end else if (tick) begin
      if (frm) begin
        if (started_q && (cnt_q == CNT_FULL)) begin
          valid_d      = 1'b1;
          fields_d.rdi = stage_q[RDI_POS];
          for (int i = 0; i < SLOT_W; i++) begin
            fields_d.rei[SLOT_W-1-i] = stage_q[REI_POS+i];
            fields_d.k1[SLOT_W-1-i]  = stage_q[K1_POS+i];
            fields_d.k2[SLOT_W-1-i]  = stage_q[K2_POS+i];
          end
        end else if (started_q && (err_q != '1)) begin
          err_d = err_q + 1'b1;
        end
        started_d        = 1'b1;
        cnt_d            = CNT_W'(1);
        stage_d[RDI_POS] = bit_in;
      end else if (started_q) begin
        if (cnt_q < CNT_FULL) begin
          if (cnt_q < CNT_USED) stage_d[cnt_q[IDX_W-1:0]] = bit_in;
          cnt_d = cnt_q + 1'b1;
        end else begin
          cnt_d = CNT_OVF;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      started_q <= 1'b0;
      mode_q    <= 1'b0;
      stage_q   <= '0;
      fields_q  <= '0;
      valid_q   <= 1'b0;
      err_q     <= '0;
    end else begin
      cnt_q     <= cnt_d;
      started_q <= started_d;
      mode_q    <= mode;
      stage_q   <= stage_d;
      fields_q  <= fields_d;
      valid_q   <= valid_d;
      err_q     <= err_d;
    end
  end

  assign fields  = fields_q;
  assign valid   = valid_q;
  assign err_cnt = err_q;

  // R8: strobe lasts one clock
  a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
  // R8: fields move only with the strobe
  a_r8_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> $stable(fields_q));
  // R7: error count moves by single steps
  a_r7_err_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(err_q) |-> (err_q == $past(err_q) + 1'b1));
  // R7: an accepted frame never counts as an error
  a_r7_accept_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> $stable(err_q));
  // R7: bit counter stays within one past a full frame
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_OVF);
  // R10: a mode change cannot produce an update in the next clock
  a_r10_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != mode_q) |=> (!valid_q && $stable(err_q)));
endmodule

// File: rtl/sa_serial_rx.sv
module sa_serial_rx
  import sa_rx_pkg::*;
#(
  parameter int DIV   = 8,
  parameter int ERR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              timing_own,
  input  logic              bit_clk_in,
  input  logic              frame_in,
  input  logic              ser_data,
  output logic              bit_clk_out,
  output logic              frame_out,
  output logic              rdi_flag,
  output logic [SLOT_W-1:0] rei_byte,
  output logic [SLOT_W-1:0] aps_k1,
  output logic [SLOT_W-1:0] aps_k2,
  output logic              word_valid,
  output logic [ERR_W-1:0]  bad_frame_cnt
);
  logic rst_m, rst_sys;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m   <= 1'b0;
      rst_sys <= 1'b0;
    end else begin
      rst_m   <= 1'b1;
      rst_sys <= rst_m;
    end
  end

  logic g_tick, g_frm;
  logic x_tick, x_frm, x_bit;
  logic rx_tick, rx_frm, rx_bit;
  sa_fields_t fields;

  sa_rx_timing_gen #(.DIV(DIV)) u_gen (
    .clk         (clk),
    .rst_n       (rst_sys),
    .en          (timing_own),
    .tick        (g_tick),
    .frm_at_tick (g_frm),
    .out_clk     (bit_clk_out),
    .out_frm     (frame_out)
  );

  sa_rx_ext_sync u_sync (
    .clk         (clk),
    .rst_n       (rst_sys),
    .ext_clk     (bit_clk_in),
    .ext_frm     (frame_in),
    .ext_dat     (ser_data),
    .tick        (x_tick),
    .frm_at_tick (x_frm),
    .bit_at_tick (x_bit)
  );

  assign rx_tick = timing_own ? g_tick   : x_tick;
  assign rx_frm  = timing_own ? g_frm    : x_frm;
  assign rx_bit  = timing_own ? ser_data : x_bit;

  sa_rx_deframer #(.ERR_W(ERR_W)) u_deframe (
    .clk     (clk),
    .rst_n   (rst_sys),
    .mode    (timing_own),
    .tick    (rx_tick),
    .frm     (rx_frm),
    .bit_in  (rx_bit),
    .fields  (fields),
    .valid   (word_valid),
    .err_cnt (bad_frame_cnt)
  );

  assign rdi_flag = fields.rdi;
  assign rei_byte = fields.rei;
  assign aps_k1   = fields.k1;
  assign aps_k2   = fields.k2;
endmodule

// File: tb/tb_sa_serial_rx.sv
module tb_sa_serial_rx;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 8;
  localparam int NBITS      = 72;
  localparam int NCO        = 7;

  logic       clk, rst_n, timing_own;
  logic       ext_clk, ext_frm, c_sdata, x_sdata, ser_data;
  logic       bit_clk_out, frame_out, rdi_flag, word_valid;
  logic [7:0] rei_byte, aps_k1, aps_k2, bad_frame_cnt;

  assign ser_data = timing_own ? c_sdata : x_sdata;

  sa_serial_rx #(.DIV(DIV), .ERR_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .timing_own(timing_own),
    .bit_clk_in(ext_clk), .frame_in(ext_frm), .ser_data(ser_data),
    .bit_clk_out(bit_clk_out), .frame_out(frame_out),
    .rdi_flag(rdi_flag), .rei_byte(rei_byte), .aps_k1(aps_k1), .aps_k2(aps_k2),
    .word_valid(word_valid), .bad_frame_cnt(bad_frame_cnt)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] rei_of(int f); return 8'((f * 37 + 5) & 255); endfunction
  function automatic logic [7:0] k1_of(int f);  return 8'((f * 11 + 33) & 255); endfunction
  function automatic logic [7:0] k2_of(int f);  return 8'(255 ^ ((f * 3) & 255)); endfunction
  function automatic logic [24:0] pack_f(int f);
    return {1'(f & 1), rei_of(f), k1_of(f), k2_of(f)};
  endfunction
  function automatic logic bit_of(int f, int i);
    logic [7:0] v;
    if (i >= NBITS) return 1'b0;
    if (i == 0) return 1'(f & 1);
    if (i >= 8 && i < 16) begin v = rei_of(f); return v[15-i]; end
    if (i >= 16 && i < 24) begin v = k1_of(f); return v[23-i]; end
    if (i >= 24 && i < 32) begin v = k2_of(f); return v[31-i]; end
    return 1'((i * 7 + f) & 1);
  endfunction
  function automatic int len_of(int k);
    if (k == 2) return NBITS - 1;
    if (k == 4) return NBITS + 1;
    return NBITS;
  endfunction

  // per-clock process state
  int n_tests_a = 0, n_fail_a = 0;
  int exp_q[$];
  logic [24:0] held_v;
  int have_prev, prev_f, prev_n, exp_err, commits, exp_commits;
  int cyc, cf, ci, lc, lf, co_bit, co_sub, co_frame;
  logic pc, pf, mode_prev, co_done;
  // sequence state
  int n_tests_i = 0, n_fail_i = 0;
  logic co_run;

  task automatic chk_a(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests_a++;
    if (!ok) begin
      n_fail_a++;
      if (n_fail_a < 20) $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_i(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests_i++;
    if (!ok) begin
      n_fail_i++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic frame_start(input int f, input int n);
    if (have_prev != 0) begin
      if (prev_n == NBITS) begin exp_q.push_back(prev_f); exp_commits++; end
      else exp_err++;
    end
    have_prev = 1; prev_f = f; prev_n = n;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      pc = 1'b0; pf = 1'b0; lc = -1; lf = -1; held_v = '0; have_prev = 0;
      exp_err = 0; commits = 0; exp_commits = 0; cf = 0; ci = 0;
      co_bit = 0; co_sub = 0; co_frame = 0; co_done = 1'b0; mode_prev = timing_own;
      ext_clk = 1'b0; ext_frm = 1'b0; c_sdata = 1'b0; x_sdata = 1'b0;
    end else begin
      if (timing_own != mode_prev) begin
        have_prev = 0; exp_commits -= exp_q.size(); exp_q.delete(); lc = -1; lf = -1;
      end
      mode_prev = timing_own;
      // R1 R4 R5 R6 R8 R9: outputs against model every clock
      if (word_valid) begin
        if (exp_q.size() == 0) chk_a(1'b0, "R8 unexpected strobe", 32'd1, 32'd0);
        else begin held_v = pack_f(exp_q.pop_front()); commits++; end
      end
      chk_a({rdi_flag, rei_byte, aps_k1, aps_k2} == held_v, "R1 R4 R5 R6 R8 fields",
            32'({rdi_flag, rei_byte, aps_k1, aps_k2}), 32'(held_v));
      if (timing_own) begin
        if (bit_clk_out && !pc) begin
          if (frame_out) begin cf++; ci = 0; frame_start(cf, NBITS); end
          else ci++;
          c_sdata = bit_of(cf, ci);
          if (lc >= 0) chk_a(cyc - lc == DIV, "R2 clock period", 32'(cyc - lc), 32'(DIV));
          lc = cyc;
        end
        if (!bit_clk_out && pc && lc >= 0)
          chk_a(cyc - lc == DIV/2, "R2 high phase", 32'(cyc - lc), 32'(DIV/2));
        if (frame_out && !pf) begin
          chk_a(bit_clk_out && !pc, "R2 pulse aligned", 32'(bit_clk_out), 32'd1);
          if (lf >= 0) chk_a(cyc - lf == NBITS*DIV, "R2 frame period", 32'(cyc - lf), 32'(NBITS*DIV));
          lf = cyc;
        end
        if (!frame_out && pf && lf >= 0)
          chk_a(cyc - lf == DIV, "R2 pulse width", 32'(cyc - lf), 32'(DIV));
      end else begin
        chk_a(!bit_clk_out && !frame_out, "R3 outputs quiet", 32'({bit_clk_out, frame_out}), 32'd0);
      end
      if (co_run && !co_done) begin
        if (co_sub == 0) begin
          if (co_bit == 0) begin cf++; frame_start(cf, len_of(co_frame)); end
          ext_frm = (co_bit == 0);
          x_sdata = bit_of(cf, co_bit);
          ext_clk = 1'b0;
        end
        if (co_sub == 3) ext_clk = 1'b1;
        co_sub++;
        if (co_sub == 6) begin
          co_sub = 0; co_bit++;
          if (co_bit == len_of(co_frame)) begin
            co_bit = 0; co_frame++;
            if (co_frame == NCO) co_done = 1'b1;
          end
        end
      end else begin
        ext_clk = 1'b0; ext_frm = 1'b0;
      end
      pc = bit_clk_out; pf = frame_out;
    end
  end

  initial begin
    rst_n = 1'b0; timing_own = 1'b0; co_run = 1'b0;
    repeat (5) @(posedge clk);
    #1;
    chk_i({rdi_flag, rei_byte, aps_k1, aps_k2, word_valid} == '0, "R1 in reset", 32'(rei_byte), 32'd0);
    chk_i(bad_frame_cnt == 0, "R1 err in reset", 32'(bad_frame_cnt), 32'd0);
    rst_n = 1'b1;
    repeat (10) @(posedge clk);
    #1;
    chk_i(word_valid == 0 && rdi_flag == 0 && aps_k1 == 0, "R1 after reset", 32'(aps_k1), 32'd0);
    chk_i(!bit_clk_out && !frame_out, "R3 idle co mode", 32'(bit_clk_out), 32'd0);
    // own timing: several frames
    timing_own = 1'b1;
    repeat (6 * NBITS * DIV + 20) @(posedge clk);
    #1;
    chk_i(bad_frame_cnt == 0, "R7 no error in own timing", 32'(bad_frame_cnt), 32'd0);
    chk_i(commits >= 4, "R5 frames accepted", 32'(commits), 32'd4);
    // external timing with a short and a long frame
    timing_own = 1'b0;
    repeat (10) @(posedge clk);
    #1 co_run = 1'b1;
    for (int w = 0; w < 20000 && !co_done; w++) @(posedge clk);
    chk_i(co_done, "R6 watchdog external sequence", 32'(co_done), 32'd1);
    repeat (20) @(posedge clk);
    #1;
    chk_i(bad_frame_cnt == 2, "R7 short and long frames counted", 32'(bad_frame_cnt), 32'd2);
    chk_i(bad_frame_cnt == 8'(exp_err), "R7 model error count", 32'(bad_frame_cnt), 32'(exp_err));
    chk_i(commits == exp_commits, "R9 neighbours accepted", 32'(commits), 32'(exp_commits));
    // back to own timing: restart without error
    timing_own = 1'b1;
    repeat (3 * NBITS * DIV + 20) @(posedge clk);
    #1;
    chk_i(bad_frame_cnt == 2, "R10 no error on restart", 32'(bad_frame_cnt), 32'd2);
    chk_i(commits == exp_commits, "R10 frames after restart", 32'(commits), 32'(exp_commits));
    chk_i(exp_q.size() <= 1, "R8 no missing strobe", 32'(exp_q.size()), 32'd0);
    $display("  [TB] %0d tests run, %0d failed", n_tests_a + n_tests_i, n_fail_a + n_fail_i);
    $finish;
  end
endmodule